// File: doc/BRIEF.md
# Three-Byte Hamming Parity Encoder for Flash Pages

This block computes a single-error-correcting parity code over flash page data as it streams past. The data arrives one byte per clock. The block treats every 256 accepted bytes as one chunk. For each chunk it produces three code bytes.

The first code byte holds column parities: XORs over chosen bit positions of every byte in the chunk. The other two code bytes hold line parities, which depend on the position of each byte that has odd parity. All three bytes are inverted at the end of the chunk, and the two lowest bits of the column byte are then forced to one.

A page of any multiple of 256 bytes yields one code per chunk, in order. A start-of-page strobe realigns the chunk boundary at any time. The next chunk may begin in the same cycle in which the previous code is presented, so the block never stalls the stream.

Top module: `hamming3_page_encoder`

## Requirements
- R1: After a synchronous active-high reset, code_valid is 0 and all three code bytes read 0. The first accepted byte after reset is position 0 of a chunk.
- R2: Column byte (code_b0): bit 2 is the chunk-wide XOR of data bits 0, 2, 4 and 6. Bit 3 covers bits 1, 3, 5 and 7. Bit 4 covers bits 0, 1, 4 and 5. Bit 5 covers bits 2, 3, 6 and 7. Bit 6 covers bits 0 to 3. Bit 7 covers bits 4 to 7. Each of these bits is inverted on output, and bits 1:0 always read 1.
- R3: Only bytes whose eight bits XOR to 1 affect the line bytes. For such a byte at chunk position p (0 to 255), each position bit p[k] toggles a line bit:
  - for k = 0 to 3, bit 2k+p[k] of code_b2;
  - for k = 4 to 7, bit 2(k-4)+p[k] of code_b1.
  Both line bytes are inverted on output.
- R4: code_valid is high for exactly one cycle: the cycle after the clock edge that accepts the 256th byte of a chunk. Between pulses the code bytes hold their last value.
- R5: A cycle with in_valid low has no effect: in_byte and in_sop are ignored, and the chunk position does not advance.
- R6: Chunks can follow each other with no gap. A byte accepted in the cycle in which a code is presented is position 0 of the next chunk. Codes appear in chunk order, one per chunk.
- R7: An accepted byte with in_sop high is position 0 of a new chunk. Any partly accumulated chunk is discarded and produces no code.
- R8: A chunk of 256 zero bytes encodes as code_b0 = code_b1 = code_b2 = 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_byte carries a data byte this cycle |
| in_sop | input | 1 | With in_valid, the byte begins a page (chunk position 0) |
| in_byte | input | 8 | Data byte |
| code_valid | output | 1 | One-cycle pulse: the code bytes belong to the chunk that just ended |
| code_b0 | output | 8 | Column parity byte |
| code_b1 | output | 8 | Line parity byte for position bits 7:4 |
| code_b2 | output | 8 | Line parity byte for position bits 3:0 |

## Verification
Two things can happen in the same cycle: the registered code of a finished chunk is presented, and the first byte of the next chunk is accepted. That first byte may also carry in_sop.

The bench provokes this by streaming chunks back to back with no idle cycles. It also starts a page with in_sop exactly on the byte that follows a finished chunk.

Each pulse is judged against an expected code that the bench computes arithmetically from the bytes it sent. The bench also checks that no spurious pulse appears and that the held code does not move between pulses.

// File: rtl/hpe_pkg.sv
package hpe_pkg;

    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 8;                 // log2 of chunk length
    localparam int CHUNK_N  = 1 << IDX_W;        // bytes per chunk
    localparam int LINE_W   = 2 * IDX_W;         // line parity bits
    localparam int FORCE_LO = 2;                 // low column bits forced high

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        byte_t line_hi;   // position bits 7:4
        byte_t line_lo;   // position bits 3:0
        byte_t col;       // column parities
    } code_t;

    // Column parity contribution of one data byte.
    function automatic byte_t col_contrib(input byte_t d);
        byte_t c;
        c    = '0;
        c[2] = d[0] ^ d[2] ^ d[4] ^ d[6];
        c[3] = d[1] ^ d[3] ^ d[5] ^ d[7];
        c[4] = d[0] ^ d[1] ^ d[4] ^ d[5];
        c[5] = d[2] ^ d[3] ^ d[6] ^ d[7];
        c[6] = ^d[3:0];
        c[7] = ^d[7:4];
        return c;
    endfunction

    // Final inversion and packing of the accumulated parities.
    function automatic code_t encode(input byte_t col_acc, input line_t line_acc);
        code_t r;
        r.col     = ~col_acc | byte_t'((1 << FORCE_LO) - 1);
        r.line_hi = ~line_acc[LINE_W-1:BYTE_W];
        r.line_lo = ~line_acc[BYTE_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/hpe_index_ctr.sv
module hpe_index_ctr #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic             sop,
    output logic [IDX_W-1:0] cur_idx,
    output logic             first,
    output logic             last
);

    logic [IDX_W-1:0] idx_q;

    assign cur_idx = sop ? '0 : idx_q;
    assign first   = (cur_idx == '0);
    assign last    = (cur_idx == {IDX_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (acc)
            idx_q <= cur_idx + 1'b1;
    end

    // R7: an accepted start strobe leaves the counter at position 1
    assert_sop_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && sop) |=> (idx_q == 1));

    // R5: idle cycles do not advance the position
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(idx_q));

endmodule

// File: rtl/hpe_col_acc.sv
module hpe_col_acc
    import hpe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  acc,
    input  logic  first,
    input  byte_t d,
    output byte_t col_next
);

    byte_t col_q;

    assign col_next = (first ? '0 : col_q) ^ col_contrib(d);

    always_ff @(posedge clk) begin
        if (rst)
            col_q <= '0;
        else if (acc)
            col_q <= col_next;
    end

endmodule

// File: rtl/hpe_line_acc.sv
module hpe_line_acc
    import hpe_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic             first,
    input  logic [IDX_W-1:0] idx,
    input  byte_t            d,
    output logic [2*IDX_W-1:0] line_next
);

    localparam int LW = 2 * IDX_W;

    logic          odd;
    logic [LW-1:0] contrib;
    logic [LW-1:0] line_q;

    assign odd = ^d;

    for (genvar k = 0; k < IDX_W; k++) begin : g_pair
        assign contrib[2*k]   = odd & ~idx[k];
        assign contrib[2*k+1] = odd &  idx[k];
    end

    assign line_next = (first ? '0 : line_q) ^ contrib;

    always_ff @(posedge clk) begin
        if (rst)
            line_q <= '0;
        else if (acc)
            line_q <= line_next;
    end

    // R3: after a chunk's first byte, either no pair or every pair holds one set bit
    assert_first_line_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && first) |=> ($countones(line_q) == 0 || $countones(line_q) == IDX_W));

endmodule

// File: rtl/hamming3_page_encoder.sv
module hamming3_page_encoder
    import hpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic [7:0] in_byte,
    output logic       code_valid,
    output logic [7:0] code_b0,
    output logic [7:0] code_b1,
    output logic [7:0] code_b2
);

    logic [IDX_W-1:0] cur_idx;
    logic             first;
    logic             last;
    byte_t            col_next;
    line_t            line_next;
    logic             done;
    code_t            code_q;
    logic             vld_q;

    hpe_index_ctr #(.IDX_W(IDX_W)) u_idx (
        .clk     (clk),
        .rst     (rst),
        .acc     (in_valid),
        .sop     (in_sop),
        .cur_idx (cur_idx),
        .first   (first),
        .last    (last)
    );

    hpe_col_acc u_col (
        .clk      (clk),
        .rst      (rst),
        .acc      (in_valid),
        .first    (first),
        .d        (in_byte),
        .col_next (col_next)
    );

    hpe_line_acc #(.IDX_W(IDX_W)) u_line (
        .clk       (clk),
        .rst       (rst),
        .acc       (in_valid),
        .first     (first),
        .idx       (cur_idx),
        .d         (in_byte),
        .line_next (line_next)
    );

    assign done = in_valid & last;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            code_q <= '0;
        end else begin
            vld_q <= done;
            if (done)
                code_q <= encode(col_next, line_next);
        end
    end

    assign code_valid = vld_q;
    assign code_b0    = code_q.col;
    assign code_b1    = code_q.line_hi;
    assign code_b2    = code_q.line_lo;

    // R4: a pulse lasts exactly one cycle
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> !code_valid);

    // R4: a pulse always follows an accepted byte
    assert_pulse_after_byte_R4: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> $past(in_valid));

    // R4: code bytes hold between pulses
    assert_code_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !code_valid |-> $stable({code_b0, code_b1, code_b2}));

endmodule

// File: tb/tb_hamming3_page_encoder.sv
module tb_hamming3_page_encoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       code_valid;
    logic [7:0] code_b0, code_b1, code_b2;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0]  chunk_mem [0:255];
    logic [23:0] exp_q [$];
    int          sw_idx = 0;
    logic        pend = 1'b0;
    logic        pend_d = 1'b0;
    logic [23:0] last_code = 24'h0;
    logic [15:0] lfsr = 16'hACE1;
    logic        mon_on = 1'b0;

    always #5 clk = ~clk;

    hamming3_page_encoder dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_byte    (in_byte),
        .code_valid (code_valid),
        .code_b0    (code_b0),
        .code_b1    (code_b1),
        .code_b2    (code_b2)
    );

    // Expected code {b0,b1,b2} of the bytes held in chunk_mem
    function automatic logic [23:0] model();
        logic [7:0] e0, e1, e2, b;
        e0 = 0; e1 = 0; e2 = 0;
        for (int i = 0; i < 256; i++) begin
            b = chunk_mem[i];
            e0[2] = e0[2] ^ b[0] ^ b[2] ^ b[4] ^ b[6];
            e0[3] = e0[3] ^ b[1] ^ b[3] ^ b[5] ^ b[7];
            e0[4] = e0[4] ^ b[0] ^ b[1] ^ b[4] ^ b[5];
            e0[5] = e0[5] ^ b[2] ^ b[3] ^ b[6] ^ b[7];
            e0[6] = e0[6] ^ b[0] ^ b[1] ^ b[2] ^ b[3];
            e0[7] = e0[7] ^ b[4] ^ b[5] ^ b[6] ^ b[7];
            if ((b[0]+b[1]+b[2]+b[3]+b[4]+b[5]+b[6]+b[7]) % 2 == 1) begin
                for (int k = 0; k < 8; k++) begin
                    int pos;
                    pos = 2 * (k % 4) + ((i >> k) & 1);
                    if (k < 4) e2[pos] = ~e2[pos];
                    else       e1[pos] = ~e1[pos];
                end
            end
        end
        e0 = ~e0 | 8'h03;
        return {e0, ~e1, ~e2};
    endfunction

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic send(input logic [7:0] b, input logic sop);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_sop   = sop;
        in_byte  = b;
        if (sop) sw_idx = 0;
        chunk_mem[sw_idx] = b;
        if (sw_idx == 255) begin
            exp_q.push_back(model());
            pend = 1'b1;
        end else begin
            pend = 1'b0;
        end
        sw_idx = (sw_idx + 1) % 256;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_sop   = 1'b1;          // R5: garbage strobe while idle
            lfsr     = lfsr_next(lfsr);
            in_byte  = lfsr[7:0];
            pend     = 1'b0;
        end
    endtask

    always @(posedge clk) pend_d <= rst ? 1'b0 : pend;

    // Output monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (pend_d || code_valid) begin
                checks++;
                if (code_valid !== pend_d) begin
                    errors++;
                    $display("FAIL R4 R6 pulse timing: code_valid got %b exp %b", code_valid, pend_d);
                end else if (exp_q.size() != 0) begin
                    logic [23:0] ev;
                    ev = exp_q.pop_front();
                    checks++;
                    if ({code_b0, code_b1, code_b2} !== ev) begin
                        errors++;
                        $display("FAIL R2 R3 R6 code: got %h exp %h", {code_b0, code_b1, code_b2}, ev);
                    end
                end
                last_code = {code_b0, code_b1, code_b2};
            end else begin
                checks++;
                if ({code_b0, code_b1, code_b2} !== last_code) begin
                    errors++;
                    $display("FAIL R4 hold: got %h exp %h", {code_b0, code_b1, code_b2}, last_code);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired: got running exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (code_valid !== 1'b0 || {code_b0, code_b1, code_b2} !== 24'h0) begin
            errors++;
            $display("FAIL R1 reset: got %b %h exp 0 000000", code_valid, {code_b0, code_b1, code_b2});
        end
        mon_on = 1'b1;

        // R8 / R1: all-zero chunk with no start strobe, first byte is position 0
        for (int i = 0; i < 256; i++) send(8'h00, 1'b0);
        idle(2);
        checks++;
        if ({code_b0, code_b1, code_b2} !== 24'hFFFFFF) begin
            errors++;
            $display("FAIL R8 zero chunk: got %h exp ffffff", {code_b0, code_b1, code_b2});
        end

        // R2 R3 R6: single-bit chunks back to back, no idle cycle between
        for (int p = 0; p < 16; p++) begin
            for (int i = 0; i < 256; i++)
                send((i == (p * 37) % 256) ? 8'(1 << (p % 8)) : 8'h00, 1'b0);
        end
        idle(2);

        // R2 R3 R5: pseudo-random chunks with idle gaps and garbage inputs
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 256; i++) begin
                lfsr = lfsr_next(lfsr);
                send(lfsr[7:0], 1'b0);
                if (i % 5 == 3) idle(1 + (i % 2));
            end
        end
        idle(2);

        // R7: partial chunk discarded by a start strobe
        for (int i = 0; i < 100; i++) begin
            lfsr = lfsr_next(lfsr);
            send(lfsr[15:8], 1'b0);
        end
        for (int i = 0; i < 256; i++) begin
            lfsr = lfsr_next(lfsr);
            send(lfsr[7:0], i == 0);
        end
        // R6 R7: start strobe on the byte accepted in the output cycle
        for (int i = 0; i < 256; i++) begin
            lfsr = lfsr_next(lfsr);
            send(lfsr[7:0] | 8'h01, i == 0);
        end
        idle(4);

        // R6: every expected code was emitted
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 codes outstanding: got %0d exp 0", exp_q.size());
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule